// File: doc/BRIEF.md
# Ternary Line-Code Decoder

This block turns a stream of three-level line symbols back into the binary data that produced them. One symbol arrives on every clock as three one-hot lines: negative pulse, zero, positive pulse. A zero gives a 0 bit. A pulse whose polarity is opposite to the last pulse gives a 1 bit.

The line code replaces each run of four zero bits with a four-slot pattern. That pattern ends in a pulse with the same polarity as the pulse before it, which is called a violation. When needed, the pattern also starts with a balancing pulse in its first slot. The decoder remembers the polarity of the last pulse so that it can spot the violation. It holds the last three decoded bits in a short delay line. When a violation arrives, it zeroes that slot and the three slots before it, so a balancing pulse that was already received never reaches the output. The recovered bit therefore appears three cycles after its symbol, with a valid strobe. A separate flag marks symbols that are not one-hot, and that flag is aligned with the bit it belongs to.

Top module: `tlc_decoder`

## Requirements
- R1: While reset is held, and during the first three symbol cycles after it is released, `valid_o`, `bit_o` and `illegal_o` are all 0.
- R2: The symbol code is `sym_i[0]` = negative, `sym_i[1]` = zero, `sym_i[2]` = positive. A zero decodes to 0. A pulse whose polarity differs from the last pulse polarity decodes to 1.
- R3: A pulse with the same polarity as the last pulse is a violation and decodes to 0.
- R4: A violation forces to 0 the three slots received just before it. This includes the slot being output in the same cycle.
- R5: The last pulse polarity is negative after reset. Every legal pulse updates it, whether it is data or a violation. Zeros and illegal codes leave it unchanged.
- R6: A code with no line set, or with more than one line set, decodes to 0. It raises `illegal_o` in the cycle its slot is output, and it is never a violation.
- R7: The result for a symbol applied in cycle t appears in cycle t+3. `valid_o` is 1 from the fourth symbol cycle after reset onward.
- R8: For any data sequence encoded by the matching substitution line code, starting from a negative last polarity and an even pulse count, the decoded bits equal the data three cycles later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one symbol per rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| sym_i | input | 3 | One-hot symbol: bit 0 negative, bit 1 zero, bit 2 positive |
| bit_o | output | 1 | Recovered data bit |
| valid_o | output | 1 | Output slot holds a real symbol result |
| illegal_o | output | 1 | Output slot came from a non-one-hot code |

## Verification
The hardest case to reach is a violation arriving while the balancing pulse it must cancel is already on the output pins. That can only be caught through the same-cycle masking path, and a plain encoder stream produces it only after an even number of pulses. The bench sweeps every 10-bit data word through an encoder model in the bench, which yields every balancing and non-balancing substitution at every offset. It then sweeps every four-symbol sequence of all eight raw codes. That second sweep reaches violations with stacked clears, illegal codes between pulses, and violations that occur right after reset.

// File: rtl/tlc_pkg.sv
package tlc_pkg;

  localparam int SYM_W    = 3;
  localparam int IDX_NEG  = 0;
  localparam int IDX_ZERO = 1;
  localparam int IDX_POS  = 2;

  typedef enum logic {
    POL_NEG = 1'b0,
    POL_POS = 1'b1
  } pol_e;

  typedef struct packed {
    logic legal;
    logic pulse;
    pol_e pol;
  } sym_info_t;

  // Splits a raw code into legality, pulse presence and pulse polarity.
  function automatic sym_info_t classify(input logic [SYM_W-1:0] s);
    sym_info_t r;
    r.legal = ($countones(s) == 1);
    r.pulse = r.legal && !s[IDX_ZERO];
    r.pol   = s[IDX_POS] ? POL_POS : POL_NEG;
    return r;
  endfunction

  // A pulse repeating the previous polarity marks a substitution.
  function automatic logic is_violation(input sym_info_t i, input pol_e last);
    return i.pulse && (i.pol == last);
  endfunction

  // Data bit carried by one slot before any later clearing.
  function automatic logic slot_bit(input sym_info_t i, input pol_e last);
    return i.pulse && (i.pol != last);
  endfunction

endpackage

// File: rtl/tlc_classify.sv
module tlc_classify
  import tlc_pkg::*;
#(
  parameter pol_e RESET_POL = POL_NEG
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SYM_W-1:0] sym_i,
  output logic             legal_o,
  output logic             viol_o,
  output logic             bit_o,
  output pol_e             last_pol_o
);

  sym_info_t info;
  pol_e      last_q;

  always_comb begin
    info    = classify(sym_i);
    legal_o = info.legal;
    viol_o  = is_violation(info, last_q);
    bit_o   = slot_bit(info, last_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_q <= RESET_POL;
    end else if (info.pulse) begin
      last_q <= info.pol;
    end
  end

  assign last_pol_o = last_q;

endmodule

// File: rtl/tlc_delay.sv
module tlc_delay #(
  parameter int DEPTH = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_i,
  input  logic ill_i,
  input  logic clear_i,
  output logic tail_bit_o,
  output logic tail_ill_o
);

  logic [DEPTH-1:0] bit_q;
  logic [DEPTH-1:0] ill_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_q[0] <= 1'b0;
      ill_q[0] <= 1'b0;
    end else begin
      bit_q[0] <= bit_i & ~clear_i;
      ill_q[0] <= ill_i;
    end
  end

  for (genvar k = 1; k < DEPTH; k++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        bit_q[k] <= 1'b0;
        ill_q[k] <= 1'b0;
      end else begin
        bit_q[k] <= bit_q[k-1] & ~clear_i;
        ill_q[k] <= ill_q[k-1];
      end
    end
  end

  // The oldest slot is cleared in the same cycle as the violation.
  assign tail_bit_o = bit_q[DEPTH-1] & ~clear_i;
  assign tail_ill_o = ill_q[DEPTH-1];

endmodule

// File: rtl/tlc_fill.sv
module tlc_fill #(
  parameter int DEPTH = 3
) (
  input  logic clk,
  input  logic rst_n,
  output logic full_o
);

  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [CW-1:0] LIMIT = CW'(DEPTH);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_q != LIMIT) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign full_o = (cnt_q == LIMIT);

endmodule

// File: rtl/tlc_decoder.sv
module tlc_decoder
  import tlc_pkg::*;
#(
  parameter int   DEPTH     = 3,
  parameter pol_e RESET_POL = POL_NEG
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] sym_i,
  output logic       bit_o,
  output logic       valid_o,
  output logic       illegal_o
);

  logic legal_w;
  logic viol_w;
  logic slot_bit_w;
  pol_e last_pol_w;
  logic tail_bit_w;
  logic tail_ill_w;
  logic full_w;

  tlc_classify #(.RESET_POL(RESET_POL)) u_cls (
    .clk        (clk),
    .rst_n      (rst_n),
    .sym_i      (sym_i),
    .legal_o    (legal_w),
    .viol_o     (viol_w),
    .bit_o      (slot_bit_w),
    .last_pol_o (last_pol_w)
  );

  tlc_delay #(.DEPTH(DEPTH)) u_dly (
    .clk        (clk),
    .rst_n      (rst_n),
    .bit_i      (slot_bit_w),
    .ill_i      (~legal_w),
    .clear_i    (viol_w),
    .tail_bit_o (tail_bit_w),
    .tail_ill_o (tail_ill_w)
  );

  tlc_fill #(.DEPTH(DEPTH)) u_fill (
    .clk    (clk),
    .rst_n  (rst_n),
    .full_o (full_w)
  );

  assign bit_o     = tail_bit_w;
  assign illegal_o = tail_ill_w;
  assign valid_o   = full_w;

endmodule

// File: rtl/tlc_decoder_chk.sv
module tlc_decoder_chk
  import tlc_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic [2:0] sym_i,
  input logic       bit_o,
  input logic       valid_o,
  input logic       illegal_o,
  input logic       legal_w,
  input logic       viol_w,
  input pol_e       last_pol_w
);

  assert_quiet_until_valid_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_o |-> (!bit_o && !illegal_o));

  assert_valid_sticks_R7: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |=> valid_o);

  assert_viol_masks_output_R4: assert property (@(posedge clk) disable iff (!rst_n)
    viol_w |-> !bit_o);

  assert_illegal_keeps_pol_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !legal_w |=> $stable(last_pol_w));

  assert_viol_keeps_pol_R5: assert property (@(posedge clk) disable iff (!rst_n)
    viol_w |=> $stable(last_pol_w));

  assert_illegal_not_viol_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(sym_i) != 1) |-> !viol_w);

endmodule

bind tlc_decoder tlc_decoder_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .sym_i      (sym_i),
  .bit_o      (bit_o),
  .valid_o    (valid_o),
  .illegal_o  (illegal_o),
  .legal_w    (legal_w),
  .viol_w     (viol_w),
  .last_pol_w (last_pol_w)
);

// File: tb/tb_tlc_decoder.sv
module tb_tlc_decoder;

  localparam logic [2:0] C_NEG  = 3'b001;
  localparam logic [2:0] C_ZERO = 3'b010;
  localparam logic [2:0] C_POS  = 3'b100;
  localparam int MAXN = 16;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] sym_i = C_ZERO;
  logic       bit_o, valid_o, illegal_o;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  logic [2:0] seq   [MAXN];
  logic       exp_b [MAXN];
  logic       exp_i [MAXN];
  string      tag   [MAXN];

  tlc_decoder dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .sym_i     (sym_i),
    .bit_o     (bit_o),
    .valid_o   (valid_o),
    .illegal_o (illegal_o)
  );

  always #4 clk = ~clk;

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      fails++;
      $display("FAIL watchdog act=%0d exp<150000", cycles);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  task automatic chk(input string t, input logic [2:0] act, input logic [2:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s {valid,bit,ill} act=%b exp=%b", t, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    sym_i = C_ZERO;
    @(negedge clk);
    #1 chk("R1 in reset", {valid_o, bit_o, illegal_o}, 3'b000);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  // Feeds n symbols and three flush zeros; compares each output cycle.
  task automatic play(input int n);
    for (int j = 0; j < n + 3; j++) begin
      sym_i = (j < n) ? seq[j] : C_ZERO;
      #3;
      if (j < 3) chk("R1", {valid_o, bit_o, illegal_o}, 3'b000);
      else chk(tag[j-3], {valid_o, bit_o, illegal_o}, {1'b1, exp_b[j-3], exp_i[j-3]});
      @(negedge clk);
    end
  endtask

  // Reference decode of a raw sequence, written from the requirements.
  task automatic model_raw(input int n);
    logic last = 1'b0;
    logic odd_hist = 1'b0;
    logic cleared [MAXN];
    logic isviol  [MAXN];
    for (int k = 0; k < n; k++) begin
      cleared[k] = 1'b0;
      isviol[k]  = 1'b0;
    end
    for (int k = 0; k < n; k++) begin
      logic legal, pulse, pol;
      legal = (seq[k] == C_NEG) || (seq[k] == C_ZERO) || (seq[k] == C_POS);
      pulse = legal && (seq[k] != C_ZERO);
      pol   = (seq[k] == C_POS);
      exp_i[k] = !legal;
      exp_b[k] = pulse && (pol != last);
      if (pulse && pol == last) begin
        isviol[k] = 1'b1;
        for (int m = k - 3; m < k; m++)
          if (m >= 0) begin
            exp_b[m] = 1'b0;
            cleared[m] = 1'b1;
          end
      end
      if (pulse) last = pol;
      if (!legal) tag[k] = "R6 illegal";
      else if (cleared[k]) tag[k] = "R4 cleared";
      else if (isviol[k]) tag[k] = "R3 violation";
      else if (pulse && odd_hist) tag[k] = "R5 polarity";
      else if (pulse) tag[k] = "R2 pulse";
      else tag[k] = "R7 zero slot";
      if (!legal || isviol[k]) odd_hist = 1'b1;
    end
    // later clears override tags set earlier
    for (int k = 0; k < n; k++)
      if (cleared[k] && !exp_i[k]) tag[k] = "R4 cleared";
  endtask

  // Encoder model: substitutes each run of four zero bits.
  task automatic encode(input logic [9:0] data);
    logic last = 1'b0;
    int   cnt = 0;
    int   i = 0;
    while (i < 10) begin
      if (i + 3 < 10 && data[i] == 0 && data[i+1] == 0 && data[i+2] == 0 && data[i+3] == 0) begin
        logic v;
        if (cnt % 2 == 0) begin
          v = ~last;
          seq[i] = v ? C_POS : C_NEG;
        end else begin
          v = last;
          seq[i] = C_ZERO;
        end
        seq[i+1] = C_ZERO;
        seq[i+2] = C_ZERO;
        seq[i+3] = v ? C_POS : C_NEG;
        last = v;
        cnt = 0;
        i += 4;
      end else begin
        if (data[i]) begin
          last = ~last;
          seq[i] = last ? C_POS : C_NEG;
          cnt++;
        end else begin
          seq[i] = C_ZERO;
        end
        i++;
      end
    end
    for (int k = 0; k < 10; k++) begin
      exp_b[k] = data[k];
      exp_i[k] = 1'b0;
      tag[k]   = "R8 chained data";
    end
  endtask

  initial begin
    // Directed: balancing pattern with the pulse already on the output.
    do_reset();
    seq[0] = C_POS; seq[1] = C_NEG; seq[2] = C_POS; seq[3] = C_ZERO;
    seq[4] = C_ZERO; seq[5] = C_POS;
    model_raw(6);
    play(6);

    for (int d = 0; d < 1024; d++) begin
      do_reset();
      encode(10'(d));
      play(10);
    end

    for (int s = 0; s < 4096; s++) begin
      logic [11:0] v;
      v = 12'(s);
      do_reset();
      for (int k = 0; k < 4; k++) seq[k] = v[3*k +: 3];
      model_raw(4);
      play(4);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule